// File: doc/BRIEF.md
# PIO Bus Cycle Timing Sequencer

This block runs one read or one write cycle at a time on a parallel PIO storage bus, acting as the host side. A requester presents an address, a direction, a width select and write data with a level request. The sequencer drives the five-bit device address, waits out the address setup time, asserts the read or write strobe, holds it for the pulse time, releases it and then waits out the recovery time. After that it returns a one-cycle acknowledge together with the captured read data and a timeout flag.

All timing comes from five speed modes. Each nanosecond minimum is converted into clock counts by rounding up against a clock-period parameter. The strobe pulse is lengthened where needed, so that setup, pulse and recovery together meet the mode's minimum cycle time. The device can slow a cycle through its ready line. That line passes through a two-flop synchronizer and is looked at once, at a fixed point after the strobe asserts. The strobe is stretched only if ready is low at that point, and an optional limit ends a stretch that never finishes.

Top module: `pio_cycle_seq`

## Requirements
- R1: A request (`req_valid` high) is accepted only while the sequencer is idle and `rsp_ack` is low. From the accepting edge until the acknowledge, `bus_addr` carries `req_addr` ({chip select 1, chip select 0, address bits 2..0}) and does not change.
- R2: With a 4 ns clock, the strobe asserts exactly S cycles after the accepting edge. S is the rounded-up address setup of 70, 50, 30, 30 and 25 ns for modes 0 to 4, which gives 18, 13, 8, 8 and 7 cycles.
- R3: Without wait states the strobe stays active for P cycles. P is the rounded-up larger of the pulse width (165, 125, 100, 80, 70 ns) and the write data setup (60, 45, 30, 30, 20 ns). If S+P+R falls short of the rounded-up cycle time (600, 383, 240, 180, 120 ns), P is raised to fill the gap. For modes 0 to 4 this gives P = 124, 78, 48, 20 and 18.
- R4: After the strobe deasserts, `rsp_ack` pulses high for one cycle after exactly R cycles. R is the rounded-up larger of the recovery minimum (none, none, none, 70 ns, 25 ns) and the data hold time (30, 20, 15, 10, 10 ns), which gives 8, 5, 4, 18 and 7.
- R5: Mode codes 5, 6 and 7 give the same timing as mode 4.
- R6: With `strobe_pol` = 0 the strobes are active low. With `strobe_pol` = 1 they are active high. Only `bus_rd_stb` is activated for reads and only `bus_wr_stb` for writes.
- R7: On writes, `bus_dq_oe` is high from the accepting edge through recovery and is low again in the acknowledge cycle. `bus_dq_o` carries all 16 bits when `req_wide` = 1, and `{8'h00, low byte}` otherwise. `bus_dq_oe` stays low for reads.
- R8: Read data is taken from `bus_dq_i` on the edge at which the strobe deasserts. It is returned on `rsp_rdata` as all 16 bits when `req_wide` = 1, and as `{8'h00, low byte}` otherwise.
- R9: `bus_ready` passes through two flops and is sampled once, on the edge at which the strobe has been active for 9 cycles. A low level that does not reach that sample causes no stretch.
- R10: If the sample of R9 is low, the strobe does not deassert at the end of P. It deasserts on the first later edge at which the synchronized ready is high. If ready is already high again when P ends, the cycle keeps its nominal length.
- R11: With `tmo_en` = 1 and limit L, a stretch that ready never ends deasserts the strobe L+1 cycles after P ends. In that case `rsp_timeout` is high during the acknowledge. `rsp_timeout` is low in every other acknowledge and whenever `rsp_ack` is low.
- R12: During and directly after reset both strobes are inactive, and `bus_dq_oe` and `rsp_ack` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request level, held until acknowledged |
| req_write | input | 1 | 1 = write cycle, 0 = read cycle |
| req_wide | input | 1 | 1 = 16-bit transfer, 0 = low byte only |
| req_addr | input | 5 | Device address {cs1, cs0, a2, a1, a0} |
| req_wdata | input | 16 | Write data |
| req_mode | input | 3 | Speed mode 0..4 (5..7 act as 4) |
| strobe_pol | input | 1 | 0 = active-low strobes, 1 = active-high |
| tmo_en | input | 1 | Enables the wait-state limit |
| tmo_limit | input | 16 | Wait-state limit L in cycles |
| rsp_ack | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Captured read data |
| rsp_timeout | output | 1 | Stretch ended by the limit, valid with ack |
| bus_addr | output | 5 | Device address to the bus |
| bus_rd_stb | output | 1 | Read strobe pin level |
| bus_wr_stb | output | 1 | Write strobe pin level |
| bus_dq_o | output | 16 | Data bus output value |
| bus_dq_oe | output | 1 | Data bus output enable |
| bus_dq_i | input | 16 | Data bus input value |
| bus_ready | input | 1 | Device ready (asynchronous) |

## Verification
The hardest situation to reach from the ports is one where the ready line is high at exactly the single sampling point but low on both sides of it. Only that pattern separates a sequencer that samples once from one that keeps watching ready until the pulse ends. The bench's device model counts the cycles of strobe activity and holds ready low for a programmed span. It can punch a one-cycle high hole at a chosen count. Placing the hole on the sampled count and then one count later gives a nominal cycle in the first case and a stretched one in the second.

// File: rtl/pio_seq_pkg.sv
`timescale 1ns/1ps
package pio_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_PULSE,
    ST_WAIT,
    ST_RECOV
  } pio_state_e;

  // Rounded-up conversion of a nanosecond minimum into clock cycles.
  function automatic int ns2cyc(input int ns, input int clk_ns);
    if (ns <= 0) return 0;
    return (ns + clk_ns - 1) / clk_ns;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // Address valid ahead of the strobe.
  function automatic int addr_lead_ns(input int m);
    case (m)
      0: return 70;
      1: return 50;
      2, 3: return 30;
      default: return 25;
    endcase
  endfunction

  // Strobe active width.
  function automatic int active_ns(input int m);
    case (m)
      0: return 165;
      1: return 125;
      2: return 100;
      3: return 80;
      default: return 70;
    endcase
  endfunction

  // Write data stable before strobe release.
  function automatic int data_lead_ns(input int m);
    case (m)
      0: return 60;
      1: return 45;
      2, 3: return 30;
      default: return 20;
    endcase
  endfunction

  // Write data kept after strobe release.
  function automatic int data_keep_ns(input int m);
    case (m)
      0: return 30;
      1: return 20;
      2: return 15;
      default: return 10;
    endcase
  endfunction

  // Strobe inactive time; the slower modes rely on the cycle minimum alone.
  function automatic int idle_gap_ns(input int m);
    case (m)
      3: return 70;
      4: return 25;
      default: return 0;
    endcase
  endfunction

  // Whole cycle minimum.
  function automatic int period_ns(input int m);
    case (m)
      0: return 600;
      1: return 383;
      2: return 240;
      3: return 180;
      default: return 120;
    endcase
  endfunction

endpackage

// File: rtl/pio_mode_timing.sv
`timescale 1ns/1ps
module pio_mode_timing
  import pio_seq_pkg::*;
#(
  parameter int CLK_NS    = 4,
  parameter int NUM_MODES = 5,
  parameter int MW        = 3,
  parameter int CW        = 8
) (
  input  logic [MW-1:0] mode_i,
  output logic [CW-1:0] setup_o,
  output logic [CW-1:0] pulse_o,
  output logic [CW-1:0] recov_o
);

  logic [CW-1:0] s_tab [NUM_MODES];
  logic [CW-1:0] p_tab [NUM_MODES];
  logic [CW-1:0] r_tab [NUM_MODES];

  for (genvar m = 0; m < NUM_MODES; m++) begin : g_mode
    localparam int S_C  = imax(1, ns2cyc(addr_lead_ns(m), CLK_NS));
    localparam int R_C  = imax(1, imax(ns2cyc(idle_gap_ns(m), CLK_NS),
                                       ns2cyc(data_keep_ns(m), CLK_NS)));
    localparam int PW_C = imax(1, imax(ns2cyc(active_ns(m), CLK_NS),
                                       ns2cyc(data_lead_ns(m), CLK_NS)));
    localparam int CY_C = ns2cyc(period_ns(m), CLK_NS);
    localparam int P_C  = (S_C + PW_C + R_C >= CY_C) ? PW_C : (CY_C - S_C - R_C);
    assign s_tab[m] = CW'(S_C);
    assign p_tab[m] = CW'(P_C);
    assign r_tab[m] = CW'(R_C);
  end

  logic [MW-1:0] idx;
  assign idx = (int'(mode_i) >= NUM_MODES) ? MW'(NUM_MODES - 1) : mode_i;

  assign setup_o = s_tab[idx];
  assign pulse_o = p_tab[idx];
  assign recov_o = r_tab[idx];

endmodule

// File: rtl/pio_rdy_sync.sv
`timescale 1ns/1ps
module pio_rdy_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] sh;

  always_ff @(posedge clk) begin
    if (rst) sh <= '1;
    else     sh <= {sh[STAGES-2:0], d_i};
  end

  assign q_o = sh[STAGES-1];

endmodule

// File: rtl/pio_cycle_seq.sv
`timescale 1ns/1ps
module pio_cycle_seq
  import pio_seq_pkg::*;
#(
  parameter int CLK_NS        = 4,
  parameter int DW            = 16,
  parameter int AW            = 5,
  parameter int MW            = 3,
  parameter int CW            = 8,
  parameter int TW            = 16,
  parameter int NUM_MODES     = 5,
  parameter int RDY_SAMPLE_NS = 35,
  parameter int SYNC_STAGES   = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic          req_wide,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic [MW-1:0] req_mode,
  input  logic          strobe_pol,
  input  logic          tmo_en,
  input  logic [TW-1:0] tmo_limit,
  output logic          rsp_ack,
  output logic [DW-1:0] rsp_rdata,
  output logic          rsp_timeout,
  output logic [AW-1:0] bus_addr,
  output logic          bus_rd_stb,
  output logic          bus_wr_stb,
  output logic [DW-1:0] bus_dq_o,
  output logic          bus_dq_oe,
  input  logic [DW-1:0] bus_dq_i,
  input  logic          bus_ready
);

  localparam int NW      = DW / 2;
  localparam int RDY_CYC = imax(1, ns2cyc(RDY_SAMPLE_NS, CLK_NS));

  pio_state_e    state;
  logic [CW-1:0] cnt;
  logic [TW-1:0] tcnt;
  logic [CW-1:0] pulse_q, recov_q;
  logic [CW-1:0] setup_c, pulse_c, recov_c;
  logic          is_wr, is_wide, stretch, tflag, strb_on;
  logic          rdy_s;

  pio_mode_timing #(
    .CLK_NS(CLK_NS), .NUM_MODES(NUM_MODES), .MW(MW), .CW(CW)
  ) u_timing (
    .mode_i (req_mode),
    .setup_o(setup_c),
    .pulse_o(pulse_c),
    .recov_o(recov_c)
  );

  pio_rdy_sync #(.STAGES(SYNC_STAGES)) u_rdy (
    .clk(clk), .rst(rst), .d_i(bus_ready), .q_o(rdy_s)
  );

  logic accept, sample_now, stretch_eff, pulse_last, tmo_hit, end_now;

  always_comb begin
    accept      = (state == ST_IDLE) && req_valid && !rsp_ack;
    sample_now  = (state == ST_PULSE) && (cnt == CW'(RDY_CYC - 1));
    stretch_eff = sample_now ? !rdy_s : stretch;
    pulse_last  = (state == ST_PULSE) && (cnt == pulse_q - 1'b1);
    tmo_hit     = tmo_en && (tcnt == tmo_limit);
    end_now     = (pulse_last && !(stretch_eff && !rdy_s)) ||
                  ((state == ST_WAIT) && (rdy_s || tmo_hit));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      cnt         <= '0;
      tcnt        <= '0;
      pulse_q     <= '0;
      recov_q     <= '0;
      is_wr       <= 1'b0;
      is_wide     <= 1'b0;
      stretch     <= 1'b0;
      tflag       <= 1'b0;
      strb_on     <= 1'b0;
      rsp_ack     <= 1'b0;
      rsp_rdata   <= '0;
      rsp_timeout <= 1'b0;
      bus_addr    <= '0;
      bus_dq_o    <= '0;
      bus_dq_oe   <= 1'b0;
    end else begin
      rsp_ack     <= 1'b0;
      rsp_timeout <= 1'b0;
      if (sample_now) stretch <= !rdy_s;
      if (end_now) begin
        strb_on <= 1'b0;
        cnt     <= recov_q - 1'b1;
        state   <= ST_RECOV;
        if ((state == ST_WAIT) && !rdy_s) tflag <= 1'b1;
        if (!is_wr)
          rsp_rdata <= is_wide ? bus_dq_i : {{NW{1'b0}}, bus_dq_i[NW-1:0]};
      end else begin
        case (state)
          ST_IDLE: begin
            if (accept) begin
              bus_addr  <= req_addr;
              is_wr     <= req_write;
              is_wide   <= req_wide;
              bus_dq_o  <= req_wide ? req_wdata : {{NW{1'b0}}, req_wdata[NW-1:0]};
              bus_dq_oe <= req_write;
              cnt       <= setup_c - 1'b1;
              pulse_q   <= pulse_c;
              recov_q   <= recov_c;
              stretch   <= 1'b0;
              tflag     <= 1'b0;
              state     <= ST_SETUP;
            end
          end
          ST_SETUP: begin
            if (cnt == '0) begin
              strb_on <= 1'b1;
              cnt     <= '0;
              state   <= ST_PULSE;
            end else begin
              cnt <= cnt - 1'b1;
            end
          end
          ST_PULSE: begin
            if (pulse_last) begin
              tcnt  <= '0;
              state <= ST_WAIT;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          ST_WAIT: begin
            tcnt <= tcnt + 1'b1;
          end
          ST_RECOV: begin
            if (cnt == '0) begin
              bus_dq_oe   <= 1'b0;
              rsp_ack     <= 1'b1;
              rsp_timeout <= tflag;
              state       <= ST_IDLE;
            end else begin
              cnt <= cnt - 1'b1;
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  logic rd_act, wr_act;
  assign rd_act     = strb_on && !is_wr;
  assign wr_act     = strb_on && is_wr;
  assign bus_rd_stb = strobe_pol ? rd_act : !rd_act;
  assign bus_wr_stb = strobe_pol ? wr_act : !wr_act;

endmodule

// File: rtl/pio_cycle_seq_chk.sv
`timescale 1ns/1ps
module pio_cycle_seq_chk #(
  parameter int AW = 5
) (
  input logic          clk,
  input logic          rst,
  input logic          strobe_pol,
  input logic          bus_rd_stb,
  input logic          bus_wr_stb,
  input logic [AW-1:0] bus_addr,
  input logic          bus_dq_oe,
  input logic          rsp_ack,
  input logic          rsp_timeout
);

  logic rd_act, wr_act;
  assign rd_act = strobe_pol ? bus_rd_stb : !bus_rd_stb;
  assign wr_act = strobe_pol ? bus_wr_stb : !bus_wr_stb;

  p_addr_stable_r1: assert property (@(posedge clk) disable iff (rst)
    (rd_act || wr_act) |-> $stable(bus_addr));

  p_one_strobe_r6: assert property (@(posedge clk) disable iff (rst)
    !(rd_act && wr_act));

  p_no_drive_on_read_r7: assert property (@(posedge clk) disable iff (rst)
    rd_act |-> !bus_dq_oe);

  p_release_at_ack_r7: assert property (@(posedge clk) disable iff (rst)
    rsp_ack |-> !bus_dq_oe);

  p_ack_single_r4: assert property (@(posedge clk) disable iff (rst)
    rsp_ack |=> !rsp_ack);

  p_timeout_with_ack_r11: assert property (@(posedge clk) disable iff (rst)
    rsp_timeout |-> rsp_ack);

  p_quiet_at_ack_r12: assert property (@(posedge clk) disable iff (rst)
    rsp_ack |-> (!rd_act && !wr_act));

endmodule

bind pio_cycle_seq pio_cycle_seq_chk #(.AW(AW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .strobe_pol (strobe_pol),
  .bus_rd_stb (bus_rd_stb),
  .bus_wr_stb (bus_wr_stb),
  .bus_addr   (bus_addr),
  .bus_dq_oe  (bus_dq_oe),
  .rsp_ack    (rsp_ack),
  .rsp_timeout(rsp_timeout)
);

// File: tb/sim_pio_cycle_seq.sv
`timescale 1ns/1ps
module sim_pio_cycle_seq;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0, req_write = 1'b0, req_wide = 1'b0;
  logic [4:0]  req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [2:0]  req_mode = '0;
  logic        strobe_pol = 1'b0, tmo_en = 1'b0;
  logic [15:0] tmo_limit = '0;
  logic        rsp_ack, rsp_timeout, bus_rd_stb, bus_wr_stb, bus_dq_oe;
  logic [15:0] rsp_rdata, bus_dq_o;
  logic [4:0]  bus_addr;
  logic [15:0] bus_dq_i = '0;
  logic        bus_ready = 1'b1;

  always #2 clk = ~clk;

  pio_cycle_seq u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_wide(req_wide), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_mode(req_mode), .strobe_pol(strobe_pol), .tmo_en(tmo_en),
    .tmo_limit(tmo_limit), .rsp_ack(rsp_ack), .rsp_rdata(rsp_rdata),
    .rsp_timeout(rsp_timeout), .bus_addr(bus_addr), .bus_rd_stb(bus_rd_stb),
    .bus_wr_stb(bus_wr_stb), .bus_dq_o(bus_dq_o), .bus_dq_oe(bus_dq_oe),
    .bus_dq_i(bus_dq_i), .bus_ready(bus_ready)
  );

  int errs = 0, total = 0;

  task automatic chk(input bit ok, input string rq, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual=%0d expected=%0d", rq, what, act, exp);
    end
  endtask

  // Expected timing from the requirement tables (4 ns clock).
  function automatic int up4(input int ns);
    return (ns + 3) / 4;
  endfunction
  function automatic int cl(input int m);
    return (m > 4) ? 4 : m;
  endfunction
  function automatic int e_setup(input int m);
    int t[5] = '{70, 50, 30, 30, 25};
    return up4(t[cl(m)]);
  endfunction
  function automatic int e_recov(input int m);
    int rc[5] = '{0, 0, 0, 70, 25};
    int hd[5] = '{30, 20, 15, 10, 10};
    int a = up4(rc[cl(m)]);
    int b = up4(hd[cl(m)]);
    return (a > b) ? a : b;
  endfunction
  function automatic int e_pulse(input int m);
    int pw[5] = '{165, 125, 100, 80, 70};
    int ds[5] = '{60, 45, 30, 30, 20};
    int cy[5] = '{600, 383, 240, 180, 120};
    int p = up4(pw[cl(m)]);
    int s = e_setup(m);
    int r = e_recov(m);
    if (up4(ds[cl(m)]) > p) p = up4(ds[cl(m)]);
    if (s + p + r < up4(cy[cl(m)])) p = up4(cy[cl(m)]) - s - r;
    return p;
  endfunction

  typedef struct {
    bit          wr;
    logic [4:0]  addr;
    logic [15:0] wdata;
    logic [15:0] rdata;
    bit          tout;
    int          s, p, r;
    string       rq;
  } exp_t;

  exp_t q[$];

  // Device model: ready pattern counted in strobe-active negedges.
  int dev_low = 0, dev_hole = -1, dev_k = 0;
  always @(negedge clk) begin
    bit act;
    act = strobe_pol ? (bus_rd_stb | bus_wr_stb) : !(bus_rd_stb & bus_wr_stb);
    if (act) begin
      dev_k = dev_k + 1;
      bus_ready = (dev_k > dev_low) || (dev_k == dev_hole);
    end else begin
      dev_k = 0;
      bus_ready = 1'b1;
    end
  end

  // Monitor / scoreboard.
  int  acnt = 0, scnt = 0, rcnt = 0;
  bit  seen = 0, bad_addr = 0, bad_stb = 0, bad_dat = 0;
  always @(negedge clk) begin
    if (!rst && q.size() > 0) begin
      exp_t c;
      bit rda, wra, act, wrong;
      c = q[0];
      rda = strobe_pol ? bus_rd_stb : !bus_rd_stb;
      wra = strobe_pol ? bus_wr_stb : !bus_wr_stb;
      act = c.wr ? wra : rda;
      wrong = c.wr ? rda : wra;
      if (wrong) bad_stb = 1;
      if (act) begin
        seen = 1;
        scnt++;
        if (bus_addr != c.addr) bad_addr = 1;
        if (c.wr) begin
          if (!bus_dq_oe || bus_dq_o != c.wdata) bad_dat = 1;
        end else if (bus_dq_oe) bad_dat = 1;
      end else if (rsp_ack) begin
        chk(acnt == c.s + 1, "R2", "address lead cycles", acnt - 1, c.s);
        chk(scnt == c.p, c.rq, "strobe active cycles", scnt, c.p);
        chk(rcnt == c.r, "R4", "recovery cycles", rcnt, c.r);
        chk(!bus_dq_oe, "R7", "output enable at ack", bus_dq_oe, 0);
        chk(rsp_timeout == c.tout, "R11", "timeout flag", rsp_timeout, c.tout);
        chk(!bad_addr, "R1", "address during strobe", bad_addr, 0);
        chk(!bad_stb, "R6", "wrong strobe active", bad_stb, 0);
        chk(!bad_dat, "R7", "data drive during strobe", bad_dat, 0);
        if (!c.wr)
          chk(rsp_rdata == c.rdata, "R8", "read data", rsp_rdata, c.rdata);
        acnt = 0; scnt = 0; rcnt = 0; seen = 0;
        bad_addr = 0; bad_stb = 0; bad_dat = 0;
        void'(q.pop_front());
      end else if (!seen) acnt++;
      else rcnt++;
    end
  end

  // Driver: computes the expected item, pushes it and runs the handshake.
  task automatic run(input int mode, input bit wr, input bit wide,
                     input logic [4:0] addr, input logic [15:0] data,
                     input int low, input int hole, input bit ten,
                     input int lim, input string rq);
    exp_t e;
    int p, len;
    bit to;
    p = e_pulse(mode);
    len = p;
    to = 0;
    // R9: sample sees ready from strobe-active count 9 - 2 = 7.
    if (!((7 > low) || (7 == hole))) begin
      len = -1;
      for (int m = p; m < p + 5000 && len < 0; m++) begin
        if (((m - 2) > low) || ((m - 2) == hole)) len = m;
        else if (ten && m == p + 1 + lim) begin len = m; to = 1; end
      end
    end
    e.wr = wr; e.addr = addr; e.tout = to; e.rq = rq;
    e.wdata = wide ? data : {8'h00, data[7:0]};
    e.rdata = wide ? data : {8'h00, data[7:0]};
    e.s = e_setup(mode); e.p = len; e.r = e_recov(mode);
    @(posedge clk); #1;
    dev_low = low; dev_hole = hole; bus_dq_i = data;
    tmo_en = ten; tmo_limit = 16'(lim);
    req_mode = 3'(mode); req_write = wr; req_wide = wide;
    req_addr = addr; req_wdata = data;
    q.push_back(e);
    req_valid = 1'b1;
    forever begin
      @(posedge clk); #1;
      if (rsp_ack) break;
    end
    req_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errs++; total++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 150000);
      $display("  Result: errors=%0d of %0d checks", errs, total);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    // R12 reset state
    chk(bus_rd_stb == 1'b1, "R12", "read strobe in reset", bus_rd_stb, 1);
    chk(bus_wr_stb == 1'b1, "R12", "write strobe in reset", bus_wr_stb, 1);
    chk(bus_dq_oe == 1'b0, "R12", "output enable in reset", bus_dq_oe, 0);
    chk(rsp_ack == 1'b0, "R12", "ack in reset", rsp_ack, 0);
    @(posedge clk); #1 rst = 1'b0;
    @(negedge clk);
    chk(rsp_ack == 1'b0 && bus_rd_stb && bus_wr_stb, "R12", "idle after reset", rsp_ack, 0);

    run(0, 0, 0, 5'b10000, 16'hA55A, 0, -1, 0, 0, "R3");
    run(1, 1, 1, 5'b01011, 16'h1234, 0, -1, 0, 0, "R3");
    run(2, 0, 1, 5'b10111, 16'hBEEF, 0, -1, 0, 0, "R3");
    run(3, 1, 0, 5'b01110, 16'hCDEF, 0, -1, 0, 0, "R3");
    run(4, 0, 1, 5'b11001, 16'h0F0F, 0, -1, 0, 0, "R3");
    run(7, 0, 1, 5'b00101, 16'h7E81, 0, -1, 0, 0, "R5");
    run(4, 0, 1, 5'b10010, 16'h1111, 6, -1, 0, 0, "R9");
    run(4, 0, 1, 5'b10011, 16'h2222, 40, 7, 0, 0, "R9");
    run(4, 0, 1, 5'b10100, 16'h3333, 40, 8, 0, 0, "R10");
    run(4, 1, 1, 5'b01100, 16'h4444, 12, -1, 0, 0, "R10");
    run(4, 0, 0, 5'b11111, 16'h5A5A, 1000, -1, 1, 5, "R11");
    run(4, 0, 1, 5'b00001, 16'h6B6B, 30, -1, 1, 100, "R11");
    run(2, 0, 1, 5'b00011, 16'h9C9C, 60, -1, 0, 0, "R10");
    @(posedge clk); #1 strobe_pol = 1'b1;
    @(negedge clk);
    chk(bus_rd_stb == 1'b0 && bus_wr_stb == 1'b0, "R6", "active-high idle level",
        {bus_rd_stb, bus_wr_stb}, 0);
    run(4, 0, 1, 5'b10001, 16'hD00D, 0, -1, 0, 0, "R6");
    run(4, 1, 1, 5'b01001, 16'hF00F, 0, -1, 0, 0, "R6");

    $display("  Result: errors=%0d of %0d checks", errs, total);
    $finish;
  end

endmodule